// File: doc/BRIEF.md
# Signed Dot-Product RGB Combiner Stage

This block is one pipeline stage of a fragment colour combiner. Each cycle it may accept three packed 8-bit RGB colours and a 4-bit operation code, and one clock later it presents one packed RGB result. Its main operation is a signed dot product. Every unsigned channel of the first two colours is moved into a symmetric signed range. The three per-channel products are each rounded and scaled on their own. Their sum is clamped to the channel range and the scalar is copied onto red, green and blue. This is how a normal-map lookup is turned into a grey lighting intensity.

The stage also supports a three-way modulate operation, which multiplies matching channels of all three colours. The remaining combiner modes have fixed code points but are not implemented here. Any code other than the two supported ones gives a black result and an error flag for that one result. An upstream sequencer drives the inputs with a valid strobe. The downstream stage takes the registered result whenever the output valid is high.

Top module: `rgb_dot3_combiner`

## Requirements
- R1: Operation code 6 selects the dot product and code 1 selects modulate. Codes 3 (signed add), 4 (interpolate), 5 (subtract), 8 (multiply-then-add), 9 (add-then-multiply) and every other code are unsupported in this stage.
- R2: Each packed colour holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0, for the inputs and for the output alike.
- R3: In the dot product, each channel value c of colours 0 and 1 becomes 2c−255. Each channel then gives the term (a'·b' + 128) / 256, and that division truncates toward zero, so −637/256 gives −2.
- R4: The dot-product sum of the three terms is clamped to 0..255. For example, all channels at 255 in both colours gives 255, and colour 0 at 255 with colour 1 at 0 gives 0.
- R5: For the dot product, the clamped scalar appears on all three output channels.
- R6: Modulate gives, per channel, (c0·c1·c2) / 255, truncated, and saturates at 255.
- R7: When an unsupported code is accepted, the result is 0x000000 and out_err is high for that result. For a supported code, out_err is low.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. out_rgb and out_err belong to that accepted input.
- R9: While in_valid is low, the next cycle shows out_valid and out_err low and out_rgb unchanged.
- R10: While rst_n is low at a clock edge, out_valid, out_err and out_rgb become zero, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Inputs hold an operation to accept |
| op | input | 4 | Operation code |
| src0 | input | 24 | Packed colour 0 |
| src1 | input | 24 | Packed colour 1 |
| src2 | input | 24 | Packed colour 2 (used by modulate) |
| out_valid | output | 1 | Registered result is valid |
| out_rgb | output | 24 | Registered packed result |
| out_err | output | 1 | Accepted code was unsupported |

## Verification
The bench builds the stage with its default 8-bit channel width and 4-bit code. This brings the whole code space of sixteen values within reach, and every unsupported code is swept directly. With 8-bit channels, the exhaustive corners of the remap (0, 127, 128, 255) can be driven on purpose. Among them is a vector whose result is 252 under truncation toward zero but 251 under a plain arithmetic shift. Random vectors then mix both clamp directions, the modulate saturation region and idle cycles between accepted inputs.

// File: rtl/rgb_comb_pkg.sv
// Shared code points and widths for the combiner stage.
// Assumes a 4-bit operation field; only two codes are served here.
package rgb_comb_pkg;
    localparam int OP_W  = 4;
    localparam int N_CH  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MODULATE   = 4'd1,
        OP_ADD_SIGNED = 4'd3,
        OP_LERP       = 4'd4,
        OP_SUBTRACT   = 4'd5,
        OP_DOT3       = 4'd6,
        OP_MUL_ADD    = 4'd8,
        OP_ADD_MUL    = 4'd9
    } comb_op_e;
endpackage

// File: rtl/dot3_term.sv
// One channel term of the signed dot product.
// Maps both unsigned inputs to 2c-max, multiplies them, adds half of the
// divisor and divides, truncating toward zero.
// Assumes CH_W >= 2.
module dot3_term #(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0]        a,
    input  logic [CH_W-1:0]        b,
    output logic signed [CH_W+1:0] term
);
    localparam int MAXV = (1 << CH_W) - 1;
    localparam int SW   = CH_W + 2;
    localparam int PW   = 2 * SW;
    localparam int BIAS = 1 << (CH_W - 1);
    localparam int DIV  = 1 << CH_W;

    logic signed [SW-1:0] a_s, b_s;
    logic signed [PW-1:0] prod, biased, quot;

    // Remap, multiply, bias and divide as one combinational path.
    always_comb begin
        a_s    = $signed({1'b0, a, 1'b0}) - SW'(MAXV);
        b_s    = $signed({1'b0, b, 1'b0}) - SW'(MAXV);
        prod   = PW'(a_s) * PW'(b_s);
        biased = prod + PW'(BIAS);
        quot   = biased / PW'(DIV);
        term   = SW'(quot);
    end
endmodule

// File: rtl/dot3_unit.sv
// Signed dot product of two packed colours.
// Builds one term per channel, sums them with headroom and clamps the sum
// to the unsigned channel range.
module dot3_unit #(
    parameter int CH_W = 8
) (
    input  logic [rgb_comb_pkg::N_CH*CH_W-1:0] c0,
    input  logic [rgb_comb_pkg::N_CH*CH_W-1:0] c1,
    output logic [CH_W-1:0]                    scalar
);
    localparam int NCH  = rgb_comb_pkg::N_CH;
    localparam int TW   = CH_W + 2;
    localparam int SUMW = TW + 2;
    localparam int MAXV = (1 << CH_W) - 1;

    logic signed [TW-1:0]   t [NCH];
    logic signed [SUMW-1:0] sum;

    for (genvar k = 0; k < NCH; k++) begin : g_term
        dot3_term #(.CH_W(CH_W)) u_term (
            .a    (c0[k*CH_W +: CH_W]),
            .b    (c1[k*CH_W +: CH_W]),
            .term (t[k])
        );
    end

    // Add the sign-extended terms, then saturate to 0..max.
    always_comb begin
        sum = '0;
        for (int k = 0; k < NCH; k++) begin
            sum = sum + SUMW'(t[k]);
        end
        if (sum < 0)
            scalar = '0;
        else if (sum > SUMW'(MAXV))
            scalar = CH_W'(MAXV);
        else
            scalar = CH_W'(sum);
    end
endmodule

// File: rtl/mod_lane.sv
// One channel of the three-way modulate: product of three channels divided
// by the channel maximum, truncated, saturated to the channel maximum.
module mod_lane #(
    parameter int CH_W = 8
) (
    input  logic [CH_W-1:0] a,
    input  logic [CH_W-1:0] b,
    input  logic [CH_W-1:0] c,
    output logic [CH_W-1:0] y
);
    localparam int PW   = 3 * CH_W;
    localparam int MAXV = (1 << CH_W) - 1;

    logic [PW-1:0] prod, quot;

    // Multiply, scale down and saturate.
    always_comb begin
        prod = PW'(a) * PW'(b) * PW'(c);
        quot = prod / PW'(MAXV);
        y    = (quot > PW'(MAXV)) ? CH_W'(MAXV) : CH_W'(quot);
    end
endmodule

// File: rtl/rgb_dot3_combiner.sv
// Colour combiner stage: dot product (replicated scalar) or modulate,
// selected by the operation code, registered one cycle after in_valid.
// Unsupported codes give black with an error flag. The result holds while
// idle. Synchronous active-low reset.
module rgb_dot3_combiner #(
    parameter int CH_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   in_valid,
    input  logic [rgb_comb_pkg::OP_W-1:0]          op,
    input  logic [rgb_comb_pkg::N_CH*CH_W-1:0]     src0,
    input  logic [rgb_comb_pkg::N_CH*CH_W-1:0]     src1,
    input  logic [rgb_comb_pkg::N_CH*CH_W-1:0]     src2,
    output logic                                   out_valid,
    output logic [rgb_comb_pkg::N_CH*CH_W-1:0]     out_rgb,
    output logic                                   out_err
);
    import rgb_comb_pkg::*;

    localparam int PIX_W = N_CH * CH_W;

    logic [CH_W-1:0]  dot_scalar;
    logic [PIX_W-1:0] mod_pix;
    logic [PIX_W-1:0] nxt_pix;
    logic             nxt_err;

    dot3_unit #(.CH_W(CH_W)) u_dot (
        .c0     (src0),
        .c1     (src1),
        .scalar (dot_scalar)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_mod
        mod_lane #(.CH_W(CH_W)) u_lane (
            .a (src0[k*CH_W +: CH_W]),
            .b (src1[k*CH_W +: CH_W]),
            .c (src2[k*CH_W +: CH_W]),
            .y (mod_pix[k*CH_W +: CH_W])
        );
    end

    // Select the result for the current code.
    always_comb begin
        nxt_pix = '0;
        nxt_err = 1'b0;
        case (op)
            OP_DOT3:     nxt_pix = {N_CH{dot_scalar}};
            OP_MODULATE: nxt_pix = mod_pix;
            default:     nxt_err = 1'b1;
        endcase
    end

    // Output register: capture on in_valid, hold the pixel while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid & nxt_err;
            if (in_valid)
                out_rgb <= nxt_pix;
        end
    end
endmodule

// File: rtl/rgb_dot3_combiner_chk.sv
// Protocol and structure checks for the combiner stage, bound to the top.
module rgb_dot3_combiner_chk #(
    parameter int CH_W = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               in_valid,
    input logic [rgb_comb_pkg::OP_W-1:0]      op,
    input logic                               out_valid,
    input logic [rgb_comb_pkg::N_CH*CH_W-1:0] out_rgb,
    input logic                               out_err
);
    import rgb_comb_pkg::*;

    logic served;
    always_comb served = (op == OP_DOT3) || (op == OP_MODULATE);

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_err && $stable(out_rgb)));

    p_replicate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_DOT3) |=>
        (out_rgb[0 +: CH_W] == out_rgb[CH_W +: CH_W] &&
         out_rgb[CH_W +: CH_W] == out_rgb[2*CH_W +: CH_W]));

    p_unsup_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !served) |=> (out_err && out_rgb == '0));

    p_served_noerr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && served) |=> !out_err);

    p_err_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
endmodule

bind rgb_dot3_combiner rgb_dot3_combiner_chk #(.CH_W(CH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .out_valid (out_valid),
    .out_rgb   (out_rgb),
    .out_err   (out_err)
);

// File: tb/rgb_dot3_combiner_tb.sv
module rgb_dot3_combiner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [23:0] src0 = '0, src1 = '0, src2 = '0;
    logic        out_valid, out_err;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [23:0] last_pix = '0;

    always #5 clk = ~clk;

    rgb_dot3_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src0(src0), .src1(src1), .src2(src2),
        .out_valid(out_valid), .out_rgb(out_rgb), .out_err(out_err)
    );

    function automatic int term(input int a, input int b);
        int p;
        p = (2 * a - 255) * (2 * b - 255) + 128;
        return p / 256;
    endfunction

    function automatic logic [23:0] exp_pix(input logic [3:0] o, input logic [23:0] a,
                                            input logic [23:0] b, input logic [23:0] c);
        int s;
        logic [23:0] r;
        r = '0;
        if (o == 4'd6) begin
            s = term(a[23:16], b[23:16]) + term(a[15:8], b[15:8]) + term(a[7:0], b[7:0]);
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            r = {s[7:0], s[7:0], s[7:0]};
        end else if (o == 4'd1) begin
            for (int k = 0; k < 3; k++) begin
                s = (int'(a[k*8 +: 8]) * int'(b[k*8 +: 8]) * int'(c[k*8 +: 8])) / 255;
                if (s > 255) s = 255;
                r[k*8 +: 8] = s[7:0];
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] o, input logic [23:0] a, input logic [23:0] b,
                        input logic [23:0] c, input string tag);
        logic [23:0] e;
        logic        ee;
        in_valid = 1'b1; op = o; src0 = a; src1 = b; src2 = c;
        e  = exp_pix(o, a, b, c);
        ee = !(o == 4'd6 || o == 4'd1);
        @(negedge clk);
        chk("R8 out_valid", {31'd0, out_valid}, 32'd1);
        chk({tag, " pixel"}, {8'd0, out_rgb}, {8'd0, e});
        chk("R7 out_err", {31'd0, out_err}, {31'd0, ee});
        if (o == 4'd6)
            chk("R5 replicate", {16'd0, out_rgb[23:16], out_rgb[7:0]},
                {16'd0, out_rgb[15:8], out_rgb[15:8]});
        last_pix = e;
    endtask

    task automatic idle();
        in_valid = 1'b0; op = 4'($urandom); src0 = 24'($urandom);
        src1 = 24'($urandom); src2 = 24'($urandom);
        @(negedge clk);
        chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R9 idle err", {31'd0, out_err}, 32'd0);
        chk("R9 idle hold", {8'd0, out_rgb}, {8'd0, last_pix});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D07));
        // R10: reset dominates an active input
        in_valid = 1'b1; op = 4'd6; src0 = 24'hFFFFFF; src1 = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R10 reset err", {31'd0, out_err}, 32'd0);
        chk("R10 reset pixel", {8'd0, out_rgb}, 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R4 clamp high and low
        send(4'd6, 24'hFFFFFF, 24'hFFFFFF, 24'h0, "R4 clamp high");
        chk("R4 clamp high value", {8'd0, out_rgb}, 32'hFFFFFF);
        send(4'd6, 24'hFFFFFF, 24'h000000, 24'h0, "R4 clamp low");
        chk("R4 clamp low value", {8'd0, out_rgb}, 32'h0);
        // R3 truncation toward zero: red term -637/256 -> -2, sum 252
        send(4'd6, 24'h00FF80, 24'h81FF80, 24'h0, "R3 trunc");
        chk("R3 trunc value", {24'd0, out_rgb[7:0]}, 32'd252);
        // R3 near mid-scale: 0x80 against 0x7F
        send(4'd6, 24'h80FFFF, 24'h7FFFFF, 24'h0, "R3 midscale");
        // R2 channel packing via modulate with src2 at full scale
        send(4'd1, 24'h010203, 24'h05070B, 24'hFFFFFF, "R2 packing");
        chk("R2 packing value", {8'd0, out_rgb}, 32'h050E21);
        // R6 saturation and small values
        send(4'd1, 24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF, "R6 saturate");
        send(4'd1, 24'h0A0203, 24'h0A0304, 24'h0A0405, "R6 small");
        idle();
        // R1 / R7: sweep every code, including the listed unimplemented ones
        for (int c = 0; c < 16; c++) begin
            send(4'(c), 24'($urandom), 24'($urandom), 24'($urandom), "R1 code sweep");
        end
        idle();
        // Random mix with idle gaps
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [3:0] o;
            sel = int'($urandom % 5);
            o = (sel < 2) ? 4'd6 : (sel < 4) ? 4'd1 : 4'($urandom);
            send(o, 24'($urandom), 24'($urandom), 24'($urandom), "R3/R6 random");
            if ($urandom % 8 == 0) idle();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule